// File: doc/BRIEF.md
# I2C Line Conditioner with Bus-Idle Detection

This block sits between the SCL and SDA pins of an I2C master and the rest of the controller. Each line passes through its own digital glitch filter whose length, in cycles of the undivided functional clock, is set separately for SCL and for SDA. A length of zero, or an active high-speed mode, makes the filter transparent. The filtered lines feed the master's START/STOP logic. The block's own idle timer watches the same filtered lines. When both lines have stayed high long enough, the timer raises a flag that lets the master issue a START.

The filter lengths and the idle timeout are taken from their inputs on every clock edge while the master is disabled. They are frozen while the master is enabled, so software may change them only while the master is off. The raw pin inputs are assumed to be already synchronous to the clock. There is no data stream at this block's edge, so every pin is a plain level with no handshake.

Top module: `i2c_line_conditioner`

## Requirements
- R1: While reset is asserted, bus_idle_o is 0 and the stored filter levels are 1. After reset, the idle count starts from 0 and the captured configuration is all zero until it is first loaded.
- R2: With a non-zero length L and high-speed mode off, a level on a raw line that differs from the filtered output for L or fewer consecutive clock edges never reaches that filtered output.
- R3: With a non-zero length L, a held change on a raw line reaches the filtered output at the (L+1)-th rising edge, counting the first edge that samples the new level as edge 1.
- R4: A length of 0 makes that line's filtered output equal its raw input within the same cycle.
- R5: While hs_mode_i is 1, both filtered outputs equal their raw inputs within the same cycle, whatever the lengths.
- R6: With a timeout T > 0, bus_idle_o becomes 1 after the rising edge at which both filtered lines have been high on T+1 consecutive edges. It stays 1 while both lines stay high, because the idle counter saturates.
- R7: bus_idle_o falls in the same cycle that either filtered line goes low.
- R8: A timeout of 0 holds bus_idle_o at 0.
- R9: The lengths and the timeout are captured on every edge at which master_en_i is 0 and take effect from that edge. While master_en_i is 1, changes on those inputs have no effect.
- R10: The SCL and SDA filters are independent. Each has its own length and its own count, and a pulse on one line does not affect the other line's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock, undivided |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_raw_i | input | 1 | Raw SCL level (synchronous) |
| sda_raw_i | input | 1 | Raw SDA level (synchronous) |
| scl_len_i | input | FILT_W (4) | SCL filter length in cycles, 0 = off |
| sda_len_i | input | FILT_W (4) | SDA filter length in cycles, 0 = off |
| idle_tmo_i | input | TMO_W (12) | Idle timeout in cycles, 0 = detection off |
| hs_mode_i | input | 1 | High-speed mode, bypasses both filters |
| master_en_i | input | 1 | Master enable; configuration frozen while 1 |
| scl_o | output | 1 | Filtered SCL |
| sda_o | output | 1 | Filtered SDA |
| bus_idle_o | output | 1 | Both lines high for longer than the timeout |

## Verification
A filter count left stale, or a comparison off by one, moves a filtered edge by exactly one cycle. It also lets a pulse of exactly L cycles through, or blocks a pulse of L+1 cycles. Either error shows on scl_o or sda_o within L+1 edges of the raw change. An idle counter that is not cleared, or that wraps instead of saturating, raises bus_idle_o too early or drops it while both lines are still high. This shows within T+1 edges of the lines going high. A configuration register that is not frozen while the master is enabled changes the filter delay on the very next raw transition.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  localparam int DEF_FILT_W = 4;
  localparam int DEF_TMO_W  = 12;
  localparam int NUM_LINES  = 2;
  typedef enum int {LN_SCL = 0, LN_SDA = 1} line_e;
endpackage

// File: rtl/i2cc_cfg_hold.sv
module i2cc_cfg_hold #(
  parameter int FW = 4,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en_i,
  input  logic [FW-1:0] scl_len_i,
  input  logic [FW-1:0] sda_len_i,
  input  logic [TW-1:0] tmo_i,
  output logic [FW-1:0] scl_len_o,
  output logic [FW-1:0] sda_len_o,
  output logic [TW-1:0] tmo_o
);
  logic [FW-1:0] scl_len_q, sda_len_q;
  logic [TW-1:0] tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_len_q <= '0;
      sda_len_q <= '0;
      tmo_q     <= '0;
    end else if (!master_en_i) begin
      scl_len_q <= scl_len_i;
      sda_len_q <= sda_len_i;
      tmo_q     <= tmo_i;
    end
  end

  assign scl_len_o = scl_len_q;
  assign sda_len_o = sda_len_q;
  assign tmo_o     = tmo_q;

  // R9: an enabled master freezes the captured settings
  a_r9_frozen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_en_i) && $past(rst_n) |-> $stable(scl_len_q) && $stable(sda_len_q) && $stable(tmo_q));
endmodule

// File: rtl/i2cc_glitch_filter.sv
module i2cc_glitch_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  input  logic [FW-1:0] len_i,
  input  logic          hs_i,
  output logic          filt_o
);
  logic          bypass;
  logic          out_q;
  logic [FW-1:0] cnt_q;

  assign bypass = hs_i || (len_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else if (bypass) begin
      out_q <= raw_i;
      cnt_q <= '0;
    end else if (raw_i == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= len_i) begin
      out_q <= raw_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = bypass ? raw_i : out_q;

  // R2: a filtered flip needs the raw level to have differed long enough
  a_r2_flip_needs_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(bypass) && (out_q != $past(out_q)) |-> $past(cnt_q) >= $past(len_i));
  // R3: the stored level only ever moves toward the sampled raw level
  a_r3_flip_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (out_q != $past(out_q)) |-> out_q == $past(raw_i));
  // R4/R5: a transparent filter shows the raw level
  a_r5_bypass_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> filt_o == raw_i);
endmodule

// File: rtl/i2cc_idle_timer.sv
module i2cc_idle_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [TW-1:0] tmo_i,
  output logic          idle_o
);
  localparam int CW = TW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          both_high;
  logic [CW-1:0] cnt_q;

  assign both_high = scl_i && sda_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!both_high) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_o = (tmo_i != '0) && both_high && (cnt_q > {1'b0, tmo_i});

  // R6: the counter saturates instead of wrapping
  a_r6_counter_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(cnt_q) == CNT_MAX) && $past(both_high) |-> cnt_q == CNT_MAX);
  // R6: idle requires the lines to have been high on the previous edge too
  a_r6_idle_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(scl_i) && $past(sda_i));
  // R7: any low line clears the count at the next edge
  a_r7_low_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(both_high) |-> cnt_q == '0);
endmodule

// File: rtl/i2c_line_conditioner.sv
module i2c_line_conditioner
  import i2cc_pkg::*;
#(
  parameter int FILT_W = DEF_FILT_W,
  parameter int TMO_W  = DEF_TMO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_raw_i,
  input  logic              sda_raw_i,
  input  logic [FILT_W-1:0] scl_len_i,
  input  logic [FILT_W-1:0] sda_len_i,
  input  logic [TMO_W-1:0]  idle_tmo_i,
  input  logic              hs_mode_i,
  input  logic              master_en_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              bus_idle_o
);
  logic [FILT_W-1:0]    scl_len_c, sda_len_c;
  logic [TMO_W-1:0]     tmo_c;
  logic [NUM_LINES-1:0] raw_v, filt_v;
  logic [FILT_W-1:0]    len_v [NUM_LINES];

  i2cc_cfg_hold #(.FW(FILT_W), .TW(TMO_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en_i (master_en_i),
    .scl_len_i   (scl_len_i),
    .sda_len_i   (sda_len_i),
    .tmo_i       (idle_tmo_i),
    .scl_len_o   (scl_len_c),
    .sda_len_o   (sda_len_c),
    .tmo_o       (tmo_c)
  );

  assign raw_v[LN_SCL] = scl_raw_i;
  assign raw_v[LN_SDA] = sda_raw_i;
  assign len_v[LN_SCL] = scl_len_c;
  assign len_v[LN_SDA] = sda_len_c;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2cc_glitch_filter #(.FW(FILT_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_v[g]),
      .len_i  (len_v[g]),
      .hs_i   (hs_mode_i),
      .filt_o (filt_v[g])
    );
  end

  assign scl_o = filt_v[LN_SCL];
  assign sda_o = filt_v[LN_SDA];

  i2cc_idle_timer #(.TW(TMO_W)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (filt_v[LN_SCL]),
    .sda_i  (filt_v[LN_SDA]),
    .tmo_i  (tmo_c),
    .idle_o (bus_idle_o)
  );

  // R8: a zero captured timeout keeps the idle flag low
  a_r8_zero_timeout_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_c == '0) |-> !bus_idle_o);
  // R7: idle never coexists with a low filtered line
  a_r7_idle_needs_high_lines: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle_o |-> scl_o && sda_o);
  // R1: idle flag is low while reset is held
  a_r1_reset_not_idle: assert property (@(posedge clk)
    !rst_n |-> !bus_idle_o);
endmodule

// File: tb/test_i2c_line_conditioner.sv
module test_i2c_line_conditioner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_raw, sda_raw, hs, en;
  logic [3:0]  scl_len, sda_len;
  logic [11:0] tmo;
  logic        scl_f, sda_f, idle;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5ns clk = ~clk;

  i2c_line_conditioner i_i2c_line_conditioner (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_raw_i   (scl_raw),
    .sda_raw_i   (sda_raw),
    .scl_len_i   (scl_len),
    .sda_len_i   (sda_len),
    .idle_tmo_i  (tmo),
    .hs_mode_i   (hs),
    .master_en_i (en),
    .scl_o       (scl_f),
    .sda_o       (sda_f),
    .bus_idle_o  (idle)
  );

  // each entry: raw_scl, raw_sda, exp_scl, exp_sda, exp_idle
  // config: SCL length 2, SDA length 1, timeout 3
  localparam logic [4:0] VEC [20] = '{
    5'b11_110, 5'b11_111, 5'b10_111, 5'b11_111, 5'b01_111,
    5'b01_111, 5'b11_111, 5'b10_111, 5'b10_100, 5'b00_100,
    5'b00_100, 5'b00_000, 5'b11_000, 5'b11_010, 5'b11_110,
    5'b11_110, 5'b11_110, 5'b11_110, 5'b11_111, 5'b01_111
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got scl/sda/idle=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; scl_raw = 1'b1; sda_raw = 1'b1; hs = 1'b0; en = 1'b0;
    scl_len = 4'd2; sda_len = 4'd1; tmo = 12'd3;
    repeat (3) step();
    chk("R1 reset state", {scl_f, sda_f, idle}, 3'b110);
    rst_n = 1'b1;
    step(); step();
    chk("R1 no idle right after reset", {scl_f, sda_f, idle}, 3'b110);
    en = 1'b1;

    // table: R2 R3 R6 R7 R10
    for (int i = 0; i < 20; i++) begin
      scl_raw = VEC[i][4];
      sda_raw = VEC[i][3];
      step();
      chk($sformatf("R2/R3/R6/R7/R10 vector %0d", i), {scl_f, sda_f, idle}, VEC[i][2:0]);
    end

    // R9: change while enabled has no effect
    scl_len = 4'd0;
    step();
    chk("R9 length held while enabled", {scl_f, sda_f, 1'b0}, 3'b110);
    scl_raw = 1'b1;
    step();
    chk("R9 held filter rejects pulse", {scl_f, sda_f, 1'b0}, 3'b110);

    // R9 load + R4 zero-length passthrough
    en = 1'b0;
    step();
    scl_raw = 1'b0;
    #1ns;
    chk("R4 zero length passthrough", {scl_f, sda_f, 1'b0}, 3'b010);
    scl_raw = 1'b1;
    step();

    // R5 high-speed bypass
    scl_len = 4'd3; sda_len = 4'd3;
    step();
    hs = 1'b1; sda_raw = 1'b0;
    #1ns;
    chk("R5 high-speed bypass", {scl_f, sda_f, 1'b0}, 3'b100);
    sda_raw = 1'b1; hs = 1'b0;
    step();

    // maximum length 15: R2 pulse of 15 rejected, R3 latency
    scl_len = 4'd15;
    step();
    en = 1'b1;
    for (int j = 1; j <= 15; j++) begin
      scl_raw = 1'b0;
      step();
      chk("R2 15-cycle pulse suppressed", {scl_f, 2'b00}, 3'b100);
    end
    scl_raw = 1'b1;
    step();
    chk("R2 after rejected pulse", {scl_f, 2'b00}, 3'b100);
    for (int j = 1; j <= 16; j++) begin
      scl_raw = 1'b0;
      step();
      chk($sformatf("R3 latency edge %0d", j), {scl_f, 2'b00}, {(j == 16) ? 1'b0 : 1'b1, 2'b00});
    end

    // R8 zero timeout
    en = 1'b0; scl_len = 4'd0; sda_len = 4'd0; tmo = 12'd0;
    step();
    scl_raw = 1'b1;
    repeat (10) step();
    chk("R8 zero timeout never idle", {scl_f, sda_f, idle}, 3'b110);

    // R6 largest timeout, saturation-safe counter
    tmo = 12'd4095; sda_raw = 1'b0;
    step();
    chk("R7 low line clears idle", {scl_f, sda_f, idle}, 3'b100);
    sda_raw = 1'b1;
    repeat (4095) step();
    chk("R6 not idle at timeout", {scl_f, sda_f, idle}, 3'b110);
    step();
    chk("R6 idle past timeout", {scl_f, sda_f, idle}, 3'b111);
    repeat (5) step();
    chk("R6 idle holds while high", {scl_f, sda_f, idle}, 3'b111);
    sda_raw = 1'b0;
    #1ns;
    chk("R7 idle drops same cycle", {scl_f, sda_f, idle}, 3'b100);
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule